// File: doc/BRIEF.md
# SPI Memory Frame Engine

This block is an SPI master that carries out a single chunk transfer into or out of the memory space of a little-endian DSP. A planner outside the block supplies a command byte, a 32-bit target address, the number of bytes in the frame and, for writes, how many real source bytes are left. The engine then drives one complete frame while chip select stays low. The frame holds the command, the address, a dummy phase whose length depends on the direction, and the data phase. All of it is shifted most significant bit first in SPI mode 0.

Write data is pulled from a byte stream with a valid/ready handshake. Read data is pushed out on a stream that carries a one-cycle valid strobe. Inside every data word the byte order is reversed, so that stream order matches the target's little-endian memory. Frame positions past the end of the real source data go out as zero bytes. The serial clock is the system clock divided by a parameter. The default divider gives about 6 MHz from a 50 MHz clock.

Top module: `spi_mem_frame`

## Requirements
- R1: After reset and while idle, cs_n is high, sclk is low, and busy, done, src_ready and dst_valid are all low.
- R2: The command byte selects the transfer. Bit 0 = 1 means a write and bit 0 = 0 means a read. Bits [2:1] give the data word size: 00 is 2 bytes, 01 is 4 bytes, 1x is 8 bytes. The frame length is a multiple of the word size.
- R3: Every frame starts with the command byte, followed by the four address bytes, most significant byte first. Each byte is shifted out on mosi most significant bit first.
- R4: A read frame sends 4 zero dummy bytes after the address. It then clocks in exactly len data bytes while mosi carries zeros.
- R5: A write frame sends its len data bytes straight after the address and then one zero byte. The frame is 6+len bytes in total.
- R6: On a write, the wire byte at position i of a word is source byte (word size - 1 - i) of that word.
- R7: On a write, a frame position whose source index is src_len or higher is sent as 0x00 and no stream byte is pulled for it. Exactly min(src_len, len) bytes are pulled.
- R8: On a read, each word received on miso is pushed to dst_data with its byte order reversed. The last wire byte of a word comes out first. Exactly len bytes are pushed.
- R9: SPI mode 0 applies. sclk is low whenever cs_n is high, and mosi never changes while sclk is high.
- R10: cs_n stays low from the first bit of the frame to the last, then stays high for at least 2*DIV clock cycles before the next frame.
- R11: busy is high from the accepted start until the gap after the frame ends. done pulses for one cycle, in the cycle busy falls, once per frame.
- R12: A start pulse while busy is high is ignored. The running frame is unchanged and gives exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame with the given fields (taken only when idle) |
| cmd | input | 8 | Command byte (direction and word size) |
| addr | input | 32 | Target address |
| len | input | LW | Data bytes in the frame |
| src_len | input | LW | Source bytes still available (write zero fill) |
| src_data | input | 8 | Write data byte |
| src_valid | input | 1 | Write data byte present |
| src_ready | output | 1 | Engine takes src_data this cycle |
| dst_data | output | 8 | Read data byte |
| dst_valid | output | 1 | dst_data is valid this cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can land in the same cycle. The first is a new start request arriving while a frame is still in flight. The test provokes this by pulsing start with different fields in the middle of a transfer, then judges the outcome from the wire: the captured frame must still match the first request, and exactly one done must appear. The second is source-stream stalls that coincide with a word fill. The test source deasserts valid one cycle in four, so fills stretch across gaps. The frame bytes and the pull count must still match the reversed, zero-filled model.

// File: rtl/spi_mem_frame.sv
module spi_mem_frame #(
  parameter int DIV = 4,
  parameter int LW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    cmd,
  input  logic [31:0]   addr,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] src_len,
  input  logic [7:0]    src_data,
  input  logic          src_valid,
  output logic          src_ready,
  output logic [7:0]    dst_data,
  output logic          dst_valid,
  output logic          busy,
  output logic          done,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int CW = $clog2(2*DIV) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_FILL, S_BIT, S_DRAIN, S_GAP} st_t;
  st_t st;

  logic          rd;
  logic [1:0]    wsel;
  logic [39:0]   hdr;
  logic [LW-1:0] len_r, slen_r;
  logic [LW:0]   pos;
  logic          have;
  logic [2:0]    fc, dc, bitc;
  logic [7:0]    tx, rx;
  logic [CW-1:0] dcnt;
  logic [7:0]    wbuf [8];
  logic          sclk_r, cs_r, busy_r, done_r, dv_r;
  logic [7:0]    dd_r;

  logic [2:0]    wsm, wi;
  logic [LW:0]   hdr_n, data_end, d, g;
  logic          need, in_hdr, in_dum, in_dat, in_tail, half;

  assign wsm      = (wsel == 2'd0) ? 3'd1 : (wsel == 2'd1) ? 3'd3 : 3'd7;
  assign hdr_n    = rd ? (LW+1)'(9) : (LW+1)'(5);
  assign data_end = hdr_n + {1'b0, len_r};
  assign d        = pos - hdr_n;
  assign wi       = d[2:0] & wsm;
  assign g        = d + (LW+1)'(fc);
  assign need     = g < {1'b0, slen_r};
  assign in_hdr   = pos < (LW+1)'(5);
  assign in_dum   = pos < hdr_n;
  assign in_dat   = pos < data_end;
  assign in_tail  = !rd && (pos == data_end);
  assign half     = dcnt == CW'(DIV-1);

  assign src_ready = (st == S_FILL) && need;
  assign dst_data  = dd_r;
  assign dst_valid = dv_r;
  assign busy      = busy_r;
  assign done      = done_r;
  assign sclk      = sclk_r;
  assign cs_n      = cs_r;
  assign mosi      = !cs_r & tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rd <= 1'b0; wsel <= 2'd0; hdr <= '0;
      len_r <= '0; slen_r <= '0; pos <= '0; have <= 1'b0;
      fc <= '0; dc <= '0; bitc <= '0; tx <= '0; rx <= '0; dcnt <= '0;
      sclk_r <= 1'b0; cs_r <= 1'b1; busy_r <= 1'b0; done_r <= 1'b0;
      dv_r <= 1'b0; dd_r <= '0;
      for (int i = 0; i < 8; i++) wbuf[i] <= '0;
    end else begin
      done_r <= 1'b0;
      dv_r   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rd <= !cmd[0]; wsel <= cmd[2:1]; hdr <= {cmd, addr};
          len_r <= len; slen_r <= src_len; pos <= '0; have <= 1'b0;
          cs_r <= 1'b0; busy_r <= 1'b1; st <= S_LOAD;
        end
        S_LOAD: begin
          bitc <= '0; dcnt <= '0;
          if (in_hdr) begin
            tx <= hdr[39:32]; hdr <= hdr << 8; st <= S_BIT;
          end else if (in_dum) begin
            tx <= '0; st <= S_BIT;
          end else if (in_dat) begin
            if (rd) begin
              tx <= '0; st <= S_BIT;
            end else if (!have) begin
              fc <= '0; st <= S_FILL;
            end else begin
              tx <= wbuf[wsm - wi]; st <= S_BIT;
            end
          end else if (in_tail) begin
            tx <= '0; st <= S_BIT;
          end else begin
            cs_r <= 1'b1; st <= S_GAP;
          end
        end
        S_FILL: if (!need || src_valid) begin
          wbuf[fc] <= need ? src_data : 8'h00;
          if (fc == wsm) begin
            have <= 1'b1; st <= S_LOAD;
          end else fc <= fc + 3'd1;
        end
        S_BIT: begin
          if (half) begin
            dcnt   <= '0;
            sclk_r <= !sclk_r;
            if (!sclk_r) rx <= {rx[6:0], miso};
            else if (bitc == 3'd7) begin
              pos <= pos + 1'b1;
              st  <= S_LOAD;
              if (in_dat && !in_dum) begin
                if (rd) begin
                  wbuf[wsm - wi] <= rx;
                  if (wi == wsm) begin dc <= '0; st <= S_DRAIN; end
                end else if (wi == wsm) have <= 1'b0;
              end
            end else begin
              tx <= tx << 1; bitc <= bitc + 3'd1;
            end
          end else dcnt <= dcnt + 1'b1;
        end
        S_DRAIN: begin
          dv_r <= 1'b1; dd_r <= wbuf[dc];
          if (dc == wsm) st <= S_LOAD;
          else dc <= dc + 3'd1;
        end
        S_GAP: begin
          if (dcnt == CW'(2*DIV-1)) begin
            done_r <= 1'b1; busy_r <= 1'b0; st <= S_IDLE;
          end else dcnt <= dcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R9
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R10
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  // R11
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  // R7
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && dst_valid));
  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy || done);
endmodule

// File: tb/tb_spi_mem_frame.sv
module tb_spi_mem_frame;
  localparam int DIV = 4;
  localparam int LW  = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cmd = '0, seed_r = '0;
  logic [31:0] addr = '0;
  logic [LW-1:0] len = '0, src_len = '0;
  logic [7:0] src_data, dst_data;
  logic src_valid, src_ready, dst_valid, busy, done, sclk, cs_n, mosi, miso;

  int n_run = 0, n_fail = 0;
  int sb = 0, sb_base = 0, sidx = 0, sbase = 0, dn = 0, dbase = 0;
  int vcnt = 0, done_cnt = 0, hc = 0, last_gap = 0;
  logic [7:0] mb [64];
  logic [7:0] dcap [256];

  always #10 clk = ~clk;

  spi_mem_frame #(.DIV(DIV), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
    .len(len), .src_len(src_len), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .dst_data(dst_data), .dst_valid(dst_valid),
    .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  function automatic logic [7:0] pat(int k);
    return 8'((k * 29 + 53) & 255);
  endfunction
  function automatic logic [7:0] srcb(logic [7:0] s, int i);
    return 8'((int'(s) + i * 11) & 255);
  endfunction

  assign src_valid = (vcnt % 4) != 3;
  assign src_data  = srcb(seed_r, sidx - sbase);

  always_comb begin
    automatic int r = sb - sb_base;
    automatic logic [7:0] p = pat(r / 8);
    miso = p[7 - (r % 8)];
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      automatic int r = sb - sb_base;
      if (r < 512) mb[r / 8][7 - (r % 8)] = mosi;
      sb = sb + 1;
    end
  end

  always @(posedge clk) begin
    vcnt <= vcnt + 1;
    if (src_valid && src_ready) sidx <= sidx + 1;
    if (dst_valid) begin dcap[dn % 256] <= dst_data; dn <= dn + 1; end
    if (done) done_cnt <= done_cnt + 1;
    if (cs_n) hc <= hc + 1;
    else begin
      if (hc != 0) last_gap <= hc;
      hc <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // stimulus: cmd, addr, len, src_len, seed
  localparam logic [79:0] VEC [9] = '{
    {8'h05, 32'h60030008, 16'd16, 16'd16, 8'h10},
    {8'h04, 32'h600300F8, 16'd8,  16'd0,  8'h00},
    {8'h03, 32'h60030004, 16'd4,  16'd3,  8'h40},
    {8'h02, 32'h18020010, 16'd4,  16'd0,  8'h00},
    {8'h01, 32'h18020000, 16'd6,  16'd6,  8'h77},
    {8'h00, 32'h18020A02, 16'd4,  16'd0,  8'h00},
    {8'h05, 32'h12345678, 16'd24, 16'd13, 8'hC3},
    {8'h04, 32'hDEADBEEC, 16'd16, 16'd0,  8'h00},
    {8'h05, 32'hA5A50000, 16'd0,  16'd0,  8'h99}
  };

  task automatic run_vec(input logic [79:0] v, input bit poke);
    logic [7:0] e [64];
    int n = 0, ws, d0, L, S, nb;
    bit rdf, got = 0;
    logic [7:0] c = v[79:72];
    logic [31:0] a = v[71:40];
    L = int'(v[39:24]); S = int'(v[23:8]);
    rdf = !c[0];
    ws = (c[2:1] == 2'd0) ? 2 : (c[2:1] == 2'd1) ? 4 : 8;
    e[n++] = c;
    for (int b = 3; b >= 0; b--) e[n++] = a[8*b +: 8];
    if (rdf) for (int k = 0; k < 4; k++) e[n++] = 8'h00;
    for (int k = 0; k < L; k++) begin
      int si = (k / ws) * ws + ws - 1 - (k % ws);
      e[n++] = (rdf || si >= S) ? 8'h00 : srcb(v[7:0], si);
    end
    if (!rdf) e[n++] = 8'h00;

    @(negedge clk);
    cmd = c; addr = a; len = v[39:24]; src_len = v[23:8]; seed_r = v[7:0];
    sb_base = sb; sbase = sidx; dbase = dn; d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (150) @(negedge clk);
      chk(busy && !cs_n, "R11 busy/cs mid-frame", {busy, cs_n}, 2'b10);
      cmd = 8'h00; addr = 32'hFFFFFFFF; len = 16'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 40000 && !got; t++) begin
      @(negedge clk);
      if (done_cnt != d0) got = 1;
    end
    chk(got, "R11 done seen", int'(got), 1);
    chk(!busy && cs_n && !sclk, "R11 idle after done", {busy, cs_n, sclk}, 3'b010);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, poke ? "R12 single done" : "R11 single done", done_cnt - d0, 1);
    nb = (sb - sb_base);
    chk(nb == n * 8, rdf ? "R4 frame bits" : "R5 frame bits", nb, n * 8);
    for (int k = 0; k < n && k < 64; k++) begin
      string tag;
      if (k < 5) tag = "R3 header";
      else if (rdf) tag = "R4 read mosi";
      else if (k == n - 1) tag = "R5 tail";
      else tag = "R6/R7 write data";
      chk(mb[k] == e[k], tag, mb[k], e[k]);
    end
    if (rdf) begin
      chk(dn - dbase == L, "R8 dst count", dn - dbase, L);
      for (int k = 0; k < L; k++) begin
        logic [7:0] x = pat(9 + (k / ws) * ws + ws - 1 - (k % ws));
        chk(dcap[(dbase + k) % 256] == x, "R8 dst byte", dcap[(dbase + k) % 256], x);
      end
    end else begin
      chk(sidx - sbase == ((S < L) ? S : L), "R7 pull count", sidx - sbase, (S < L) ? S : L);
      chk(dn == dbase, "R8 no dst on write", dn - dbase, 0);
    end
  endtask

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !src_ready && !dst_valid, "R1 reset state",
        {cs_n, sclk, busy, done, src_ready, dst_valid}, 6'b100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done, "R1 idle state", {cs_n, sclk, busy, done}, 4'b1000);
    for (int i = 0; i < 9; i++) run_vec(VEC[i], 1'b0);
    chk(last_gap >= 2 * DIV, "R10 cs gap", last_gap, 2 * DIV);
    // R2 word-size decode under 2/4/8 byte words is covered by the table; R12 directed
    run_vec({8'h05, 32'h0BADF00C, 16'd16, 16'd11, 8'h21}, 1'b1);
    run_vec({8'h02, 32'h00001000, 16'd8, 16'd0, 8'h00}, 1'b1);
    chk(last_gap >= 2 * DIV, "R10 cs gap back-to-back", last_gap, 2 * DIV);
    chk(!sclk && cs_n, "R9 sclk idle low", {sclk, cs_n}, 2'b01);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule